// File: doc/BRIEF.md
# SECDED Memory Data Path with Fault Injection

This block sits between the system side and a 64-bit memory data bus that stores 8 extra check bits per word. On the write side it encodes every 64-bit data word into a 72-bit stored word. The code is a Hamming code plus one overall parity bit. Before the word leaves for memory, two configuration masks can invert chosen data and check bits, so that test software can plant known faults.

On the read side it decodes each returned 72-bit word. A single-bit fault is repaired on the fly and flagged. This includes a fault that lies only in a check bit, in which case the data is already correct. When two bits are wrong the word is flagged as uncorrectable and passed on unrepaired.

After every repaired read the block raises a scrub request that carries the same address and the freshly encoded word. New reads are refused until memory acknowledges that write-back. A saturating counter tallies repaired reads. Software can clear the counter, and it can switch checking off entirely for memories that have no check bits.

Top module: `secded_path`

## Requirements
- R1: One cycle after `wr_valid` is sampled, `mem_wr_valid` is 1 and `mem_wr_addr` is the written address. `mem_wr_word` is laid out as {check[7:0], data[63:0]}. Codeword positions 1..71 are numbered, and check bit k (k = 0..6) sits at position 2^k. Data bit i takes the i-th position, counting upward from position 3, that is not a power of two. Check bit k is the XOR of all data bits whose position has bit k set. Check bit 7 makes the XOR of all 72 stored bits zero.
- R2: On every memory write, the encoded word is XORed with {`cfg_inj_chk`, `cfg_inj_data`} before it is output. Zero masks leave it unchanged.
- R3: A read accepted while `rd_ready` is 1 produces `rsp_valid` one cycle later. A word with no error returns its data with both flags at 0. Both flags are 0 in every cycle in which `rsp_valid` is 0.
- R4: A word with exactly one inverted data bit returns the repaired data, with `rsp_corrected` set to 1 and `rsp_uncorrectable` set to 0.
- R5: A word with exactly one inverted check bit, including bit 7, returns its data unchanged, with `rsp_corrected` set to 1.
- R6: When the syndrome is nonzero and the overall parity is even, or when the parity is odd but the syndrome points beyond position 71, `rsp_uncorrectable` is 1. In that case the raw data is returned, no scrub is requested and the counter does not change.
- R7: In the cycle that a repaired response appears, `scrub_req` rises. `scrub_addr` then holds the read address, and `scrub_word` holds the encoding of the repaired data XOR the injection masks. All three stay stable until `scrub_ack` is sampled high, and `scrub_req` falls in the following cycle.
- R8: While `scrub_req` is pending, `rd_ready` is 0, and a `rd_valid` presented then produces no response.
- R9: With `cfg_check_en` at 0, read data passes through raw with both flags at 0. No scrub is requested and the counter does not change.
- R10: `err_count` rises by one for each repaired read and stops at its maximum value.
- R11: When `cfg_cnt_clr` is sampled high, `err_count` is 0 in the next cycle, even if a repaired read is accepted in the same cycle.
- R12: After reset, `mem_wr_valid`, `rsp_valid`, both flags, `scrub_req` and `err_count` are 0, and `rd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_check_en | input | 1 | Enable checking and correction of read data |
| cfg_inj_data | input | 64 | Data-bit inversion mask applied on writes |
| cfg_inj_chk | input | 8 | Check-bit inversion mask applied on writes |
| cfg_cnt_clr | input | 1 | Clear the error counter |
| wr_valid | input | 1 | System write strobe |
| wr_addr | input | ADDR_W | System write address |
| wr_data | input | 64 | System write data |
| mem_wr_valid | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_word | output | 72 | Encoded word sent to memory |
| rd_valid | input | 1 | Read data from memory is present |
| rd_addr | input | ADDR_W | Address of the returned word |
| rd_word | input | 72 | Stored word returned by memory |
| rd_ready | output | 1 | Reads are accepted (no scrub pending) |
| rsp_valid | output | 1 | Response strobe to the system |
| rsp_data | output | 64 | Checked (and possibly repaired) data |
| rsp_corrected | output | 1 | A single-bit fault was repaired |
| rsp_uncorrectable | output | 1 | A multi-bit fault was detected |
| scrub_req | output | 1 | Write-back of a repaired word is pending |
| scrub_addr | output | ADDR_W | Write-back address |
| scrub_word | output | 72 | Write-back encoded word |
| scrub_ack | input | 1 | Memory has taken the write-back |
| err_count | output | CNT_W | Saturating count of repaired reads |

## Verification
Some properties are checked on every cycle: the write latency and the even parity of unmasked stored words, how the scrub request is held and released, the refusal of reads while a scrub is pending, the raw pass-through when checking is off, and the counter's step, saturation and clear rules. Other outcomes can only be shown by the bench's scenarios, because they depend on which bit was planted: whether the right data bit is repaired, whether a check-bit-only fault leaves the data untouched, how double and out-of-range faults are classified, and whether the scrub word equals the re-encoded repaired data with the injection masks applied.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int unsigned DATA_W   = 64;
    localparam int unsigned HAM_W    = $clog2(DATA_W + $clog2(DATA_W) + 1);
    localparam int unsigned CHK_W    = HAM_W + 1;
    localparam int unsigned WORD_W   = DATA_W + CHK_W;
    localparam int unsigned CODE_LEN = DATA_W + HAM_W;

    typedef struct packed {
        logic [CHK_W-1:0]  chk;
        logic [DATA_W-1:0] data;
    } code_word_t;

    typedef enum logic [1:0] {
        ECC_CLEAN = 2'd0,
        ECC_FIXED = 2'd1,
        ECC_FATAL = 2'd2
    } ecc_status_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        ecc_status_t       status;
    } decode_t;

    typedef enum logic {
        SCRUB_IDLE = 1'b0,
        SCRUB_WAIT = 1'b1
    } scrub_state_t;

    // Codeword position of data bit idx: the idx-th non-power-of-two in 1..CODE_LEN.
    function automatic int unsigned data_pos(input int unsigned idx);
        int unsigned seen;
        int unsigned pos;
        seen = 0;
        pos  = 0;
        for (int unsigned p = 1; p <= CODE_LEN; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (seen == idx) pos = p;
                seen++;
            end
        end
        return pos;
    endfunction

    // Data bits that feed Hamming check bit k.
    function automatic logic [DATA_W-1:0] ham_mask(input int unsigned k);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < DATA_W; i++) begin
            m[i] = ((data_pos(i) >> k) & 1) != 0;
        end
        return m;
    endfunction

    function automatic code_word_t inject(input code_word_t w,
                                          input logic [DATA_W-1:0] dmask,
                                          input logic [CHK_W-1:0] cmask);
        code_word_t r;
        r.data = w.data ^ dmask;
        r.chk  = w.chk ^ cmask;
        return r;
    endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output code_word_t        word_o
);

    logic [HAM_W-1:0] ham;

    for (genvar k = 0; k < HAM_W; k++) begin : g_ham
        localparam logic [DATA_W-1:0] MASK = ham_mask(k);
        assign ham[k] = ^(data_i & MASK);
    end

    assign word_o.data = data_i;
    assign word_o.chk  = {(^data_i) ^ (^ham), ham};

endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
    import secded_pkg::*;
(
    input  code_word_t word_i,
    input  logic       check_en_i,
    output decode_t    res_o
);

    code_word_t        recalc;
    logic [HAM_W-1:0]  syn;
    logic              par_odd;
    logic              in_range;
    logic [DATA_W-1:0] flip;

    ecc_encoder u_recalc (
        .data_i (word_i.data),
        .word_o (recalc)
    );

    assign syn      = recalc.chk[HAM_W-1:0] ^ word_i.chk[HAM_W-1:0];
    assign par_odd  = ^word_i;
    assign in_range = (syn <= HAM_W'(CODE_LEN));

    for (genvar i = 0; i < DATA_W; i++) begin : g_flip
        localparam logic [HAM_W-1:0] POS = HAM_W'(data_pos(i));
        assign flip[i] = (syn == POS);
    end

    always_comb begin
        res_o.data   = word_i.data;
        res_o.status = ECC_CLEAN;
        if (check_en_i) begin
            if (par_odd && in_range) begin
                res_o.status = ECC_FIXED;
                res_o.data   = word_i.data ^ flip;
            end else if (par_odd || (syn != '0)) begin
                res_o.status = ECC_FATAL;
            end
        end
    end

endmodule

// File: rtl/ecc_err_counter.sv
module ecc_err_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
        end else if (clr_i) begin
            count_o <= '0;
        end else if (inc_i && (count_o != '1)) begin
            count_o <= count_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/ecc_scrub_ctrl.sv
module ecc_scrub_ctrl
    import secded_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  code_word_t        word_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o,
    output code_word_t        word_o
);

    scrub_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SCRUB_IDLE;
            addr_o <= '0;
            word_o <= '0;
        end else begin
            case (state)
                SCRUB_IDLE: begin
                    if (start_i) begin
                        state  <= SCRUB_WAIT;
                        addr_o <= addr_i;
                        word_o <= word_i;
                    end
                end
                SCRUB_WAIT: begin
                    if (ack_i) state <= SCRUB_IDLE;
                end
                default: state <= SCRUB_IDLE;
            endcase
        end
    end

    assign req_o = (state == SCRUB_WAIT);

endmodule

// File: rtl/secded_path.sv
module secded_path
    import secded_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_check_en,
    input  logic [DATA_W-1:0] cfg_inj_data,
    input  logic [CHK_W-1:0]  cfg_inj_chk,
    input  logic              cfg_cnt_clr,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [WORD_W-1:0] mem_wr_word,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_word,
    output logic              rd_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_corrected,
    output logic              rsp_uncorrectable,
    output logic              scrub_req,
    output logic [ADDR_W-1:0] scrub_addr,
    output logic [WORD_W-1:0] scrub_word,
    input  logic              scrub_ack,
    output logic [CNT_W-1:0]  err_count
);

    code_word_t wr_enc;
    code_word_t rd_cw;
    code_word_t fix_enc;
    code_word_t scrub_cw;
    decode_t    dec;
    logic       rd_accept;
    logic       rd_fixed;

    // Write side: encode, then apply the fault-injection masks.
    ecc_encoder u_wr_enc (
        .data_i (wr_data),
        .word_o (wr_enc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_wr_valid <= 1'b0;
            mem_wr_addr  <= '0;
            mem_wr_word  <= '0;
        end else begin
            mem_wr_valid <= wr_valid;
            if (wr_valid) begin
                mem_wr_addr <= wr_addr;
                mem_wr_word <= inject(wr_enc, cfg_inj_data, cfg_inj_chk);
            end
        end
    end

    // Read side: classify and repair.
    assign rd_cw = rd_word;

    ecc_decoder u_dec (
        .word_i     (rd_cw),
        .check_en_i (cfg_check_en),
        .res_o      (dec)
    );

    assign rd_ready  = !scrub_req;
    assign rd_accept = rd_valid && rd_ready;
    assign rd_fixed  = rd_accept && (dec.status == ECC_FIXED);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid         <= 1'b0;
            rsp_data          <= '0;
            rsp_corrected     <= 1'b0;
            rsp_uncorrectable <= 1'b0;
        end else begin
            rsp_valid         <= rd_accept;
            rsp_corrected     <= rd_fixed;
            rsp_uncorrectable <= rd_accept && (dec.status == ECC_FATAL);
            if (rd_accept) rsp_data <= dec.data;
        end
    end

    // Scrub write-back of the repaired word.
    ecc_encoder u_fix_enc (
        .data_i (dec.data),
        .word_o (fix_enc)
    );

    ecc_scrub_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_scrub (
        .clk     (clk),
        .rst     (rst),
        .start_i (rd_fixed),
        .addr_i  (rd_addr),
        .word_i  (inject(fix_enc, cfg_inj_data, cfg_inj_chk)),
        .ack_i   (scrub_ack),
        .req_o   (scrub_req),
        .addr_o  (scrub_addr),
        .word_o  (scrub_cw)
    );

    assign scrub_word = scrub_cw;

    ecc_err_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (rd_fixed),
        .clr_i   (cfg_cnt_clr),
        .count_o (err_count)
    );

endmodule

// File: rtl/secded_path_chk.sv
module secded_path_chk
    import secded_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_check_en,
    input logic [DATA_W-1:0] cfg_inj_data,
    input logic [CHK_W-1:0]  cfg_inj_chk,
    input logic              cfg_cnt_clr,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              mem_wr_valid,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [WORD_W-1:0] mem_wr_word,
    input logic              rd_valid,
    input logic [WORD_W-1:0] rd_word,
    input logic              rd_ready,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_corrected,
    input logic              rsp_uncorrectable,
    input logic              scrub_req,
    input logic [ADDR_W-1:0] scrub_addr,
    input logic [WORD_W-1:0] scrub_word,
    input logic              scrub_ack,
    input logic [CNT_W-1:0]  err_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assert_write_latency_R1: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> mem_wr_valid && (mem_wr_addr == $past(wr_addr)));

    assert_write_parity_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && (cfg_inj_data == '0) && (cfg_inj_chk == '0)) |=> ((^mem_wr_word) == 1'b0));

    assert_flags_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !rsp_corrected && !rsp_uncorrectable);

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(rsp_corrected && rsp_uncorrectable));

    assert_no_scrub_fatal_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_uncorrectable |-> !scrub_req);

    assert_scrub_origin_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(scrub_req) |-> rsp_valid && rsp_corrected);

    assert_scrub_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (scrub_req && !scrub_ack) |=> scrub_req && $stable(scrub_addr) && $stable(scrub_word));

    assert_scrub_release_R7: assert property (@(posedge clk) disable iff (rst)
        (scrub_req && scrub_ack) |=> !scrub_req && rd_ready);

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> !rsp_valid);

    assert_bypass_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready && !cfg_check_en) |=>
            rsp_valid && !rsp_corrected && !rsp_uncorrectable && !scrub_req &&
            (rsp_data == $past(rd_word[DATA_W-1:0])));

    assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
        !cfg_cnt_clr |=> (err_count == $past(err_count)) ||
                         (err_count == $past(err_count) + CNT_W'(1)));

    assert_count_sat_R10: assert property (@(posedge clk) disable iff (rst)
        ((err_count == CNT_MAX) && !cfg_cnt_clr) |=> (err_count == CNT_MAX));

    assert_count_clear_R11: assert property (@(posedge clk) disable iff (rst)
        cfg_cnt_clr |=> (err_count == '0));

endmodule

bind secded_path secded_path_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk               (clk),
    .rst               (rst),
    .cfg_check_en      (cfg_check_en),
    .cfg_inj_data      (cfg_inj_data),
    .cfg_inj_chk       (cfg_inj_chk),
    .cfg_cnt_clr       (cfg_cnt_clr),
    .wr_valid          (wr_valid),
    .wr_addr           (wr_addr),
    .mem_wr_valid      (mem_wr_valid),
    .mem_wr_addr       (mem_wr_addr),
    .mem_wr_word       (mem_wr_word),
    .rd_valid          (rd_valid),
    .rd_word           (rd_word),
    .rd_ready          (rd_ready),
    .rsp_valid         (rsp_valid),
    .rsp_data          (rsp_data),
    .rsp_corrected     (rsp_corrected),
    .rsp_uncorrectable (rsp_uncorrectable),
    .scrub_req         (scrub_req),
    .scrub_addr        (scrub_addr),
    .scrub_word        (scrub_word),
    .scrub_ack         (scrub_ack),
    .err_count         (err_count)
);

// File: tb/tb_secded_path.sv
module tb_secded_path;

    localparam int AW   = 16;
    localparam int CW   = 4;
    localparam int CMAX = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_check_en = 1'b1;
    logic [63:0]   cfg_inj_data = '0;
    logic [7:0]    cfg_inj_chk = '0;
    logic          cfg_cnt_clr = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [63:0]   wr_data = '0;
    logic          mem_wr_valid;
    logic [AW-1:0] mem_wr_addr;
    logic [71:0]   mem_wr_word;
    logic          rd_valid = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [71:0]   rd_word = '0;
    logic          rd_ready;
    logic          rsp_valid;
    logic [63:0]   rsp_data;
    logic          rsp_corrected;
    logic          rsp_uncorrectable;
    logic          scrub_req;
    logic [AW-1:0] scrub_addr;
    logic [71:0]   scrub_word;
    logic          scrub_ack = 1'b0;
    logic [CW-1:0] err_count;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cycles   = 0;
    string cur_req  = "R12";

    always #2 clk = ~clk;

    secded_path #(.ADDR_W(AW), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .cfg_check_en(cfg_check_en),
        .cfg_inj_data(cfg_inj_data), .cfg_inj_chk(cfg_inj_chk), .cfg_cnt_clr(cfg_cnt_clr),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_word(mem_wr_word),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_word(rd_word), .rd_ready(rd_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_corrected(rsp_corrected),
        .rsp_uncorrectable(rsp_uncorrectable), .scrub_req(scrub_req),
        .scrub_addr(scrub_addr), .scrub_word(scrub_word), .scrub_ack(scrub_ack),
        .err_count(err_count)
    );

    // ---------------- behavioural code reference ----------------
    function automatic int pos_of(input int idx);
        int n;
        n = 0;
        for (int p = 3; p < 128; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == idx) return p;
                n++;
            end
        end
        return 0;
    endfunction

    function automatic logic [71:0] ref_enc(input logic [63:0] d);
        int s;
        logic [6:0] h;
        s = 0;
        for (int i = 0; i < 64; i++) if (d[i]) s = s ^ pos_of(i);
        h = s[6:0];
        return {(^d) ^ (^h), h, d};
    endfunction

    function automatic void ref_dec(input logic [71:0] w, output logic [63:0] d,
                                    output bit fix, output bit bad);
        int syn;
        bit par;
        syn = 0;
        for (int i = 0; i < 64; i++) if (w[i]) syn = syn ^ pos_of(i);
        for (int k = 0; k < 7; k++) if (w[64+k]) syn = syn ^ (1 << k);
        par = ^w;
        d = w[63:0];
        fix = 1'b0;
        bad = 1'b0;
        if (syn == 0 && !par) begin
        end else if (par && syn <= 71) begin
            fix = 1'b1;
            for (int i = 0; i < 64; i++) if (pos_of(i) == syn) d[i] = ~d[i];
        end else begin
            bad = 1'b1;
        end
    endfunction

    // ---------------- cycle model ----------------
    bit            e_mem_valid;
    logic [AW-1:0] e_mem_addr;
    logic [71:0]   e_mem_word;
    bit            e_rsp_valid, e_fix, e_bad, e_busy;
    logic [63:0]   e_rsp_data;
    logic [AW-1:0] e_scrub_addr;
    logic [71:0]   e_scrub_word;
    int            e_count;

    always @(posedge clk) begin : model
        logic [63:0] d;
        bit f, b, acc;
        if (rst) begin
            e_mem_valid = 0; e_rsp_valid = 0; e_fix = 0; e_bad = 0;
            e_busy = 0; e_count = 0;
        end else begin
            acc = rd_valid && !e_busy;
            d = rd_word[63:0]; f = 0; b = 0;
            if (acc && cfg_check_en) ref_dec(rd_word, d, f, b);
            e_rsp_valid = acc;
            e_fix = acc && f;
            e_bad = acc && b;
            if (acc) e_rsp_data = d;
            e_mem_valid = wr_valid;
            if (wr_valid) begin
                e_mem_addr = wr_addr;
                e_mem_word = ref_enc(wr_data) ^ {cfg_inj_chk, cfg_inj_data};
            end
            if (e_busy) begin
                if (scrub_ack) e_busy = 0;
            end else if (acc && f) begin
                e_busy = 1;
                e_scrub_addr = rd_addr;
                e_scrub_word = ref_enc(d) ^ {cfg_inj_chk, cfg_inj_data};
            end
            if (cfg_cnt_clr) e_count = 0;
            else if (acc && f && e_count < CMAX) e_count++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        chk(rsp_valid == e_rsp_valid, cur_req, "rsp_valid", 72'(rsp_valid), 72'(e_rsp_valid));
        chk(rsp_corrected == e_fix, cur_req, "rsp_corrected", 72'(rsp_corrected), 72'(e_fix));
        chk(rsp_uncorrectable == e_bad, cur_req, "rsp_uncorrectable", 72'(rsp_uncorrectable), 72'(e_bad));
        if (e_rsp_valid)
            chk(rsp_data == e_rsp_data, cur_req, "rsp_data", 72'(rsp_data), 72'(e_rsp_data));
        chk(mem_wr_valid == e_mem_valid, cur_req, "mem_wr_valid", 72'(mem_wr_valid), 72'(e_mem_valid));
        if (e_mem_valid) begin
            chk(mem_wr_addr == e_mem_addr, cur_req, "mem_wr_addr", 72'(mem_wr_addr), 72'(e_mem_addr));
            chk(mem_wr_word == e_mem_word, cur_req, "mem_wr_word", mem_wr_word, e_mem_word);
        end
        chk(scrub_req == e_busy, cur_req, "scrub_req", 72'(scrub_req), 72'(e_busy));
        chk(rd_ready == !e_busy, cur_req, "rd_ready", 72'(rd_ready), 72'(!e_busy));
        if (e_busy) begin
            chk(scrub_addr == e_scrub_addr, cur_req, "scrub_addr", 72'(scrub_addr), 72'(e_scrub_addr));
            chk(scrub_word == e_scrub_word, cur_req, "scrub_word", scrub_word, e_scrub_word);
        end
        chk(int'(err_count) == e_count, cur_req, "err_count", 72'(err_count), 72'(e_count));
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_write(input logic [AW-1:0] a, input logic [63:0] d);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [71:0] w);
        rd_valid = 1'b1; rd_addr = a; rd_word = w;
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic do_ack();
        scrub_ack = 1'b1;
        @(negedge clk);
        scrub_ack = 1'b0;
    endtask

    function automatic logic [71:0] flip1(input logic [71:0] w, input int b);
        return w ^ (72'd1 << b);
    endfunction

    initial begin
        logic [63:0] pat;
        logic [71:0] cw;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        cur_req = "R12";
        chk(rd_ready == 1'b1, "R12", "rd_ready after reset", 72'(rd_ready), 72'd1);
        chk(err_count == '0, "R12", "err_count after reset", 72'(err_count), 72'd0);
        chk(!rsp_valid && !mem_wr_valid && !scrub_req, "R12", "strobes after reset",
            72'({rsp_valid, mem_wr_valid, scrub_req}), 72'd0);

        cur_req = "R1";
        for (int i = 0; i < 6; i++) begin
            pat = (i == 0) ? 64'd0 : (i == 1) ? '1 : 64'hA5A5_0F0F_DEAD_BEEF * (i + 1);
            do_write(AW'(16'h100 + i), pat);
            chk((^mem_wr_word) == 1'b0, "R1", "stored word parity", 72'(^mem_wr_word), 72'd0);
            chk(mem_wr_word == ref_enc(pat), "R1", "stored word", mem_wr_word, ref_enc(pat));
        end

        cur_req = "R2";
        cfg_inj_data = 64'h8000_0000_0000_0020;
        cfg_inj_chk  = 8'h81;
        pat = 64'h0123_4567_89AB_CDEF;
        do_write(16'h200, pat);
        chk((mem_wr_word ^ ref_enc(pat)) == {8'h81, 64'h8000_0000_0000_0020}, "R2",
            "injected bits", mem_wr_word ^ ref_enc(pat), {8'h81, 64'h8000_0000_0000_0020});
        cfg_inj_data = '0;
        cfg_inj_chk  = '0;

        cur_req = "R3";
        pat = 64'hFEED_FACE_CAFE_F00D;
        do_read(16'h300, ref_enc(pat));
        chk(rsp_valid && rsp_data == pat && !rsp_corrected, "R3", "clean read",
            72'(rsp_data), 72'(pat));

        cur_req = "R4";
        foreach (pat[b]) begin
            if (b % 21 != 0) continue;
            do_read(AW'(16'h400 + b), flip1(ref_enc(64'h1357_9BDF_2468_ACE0), b));
            chk(rsp_data == 64'h1357_9BDF_2468_ACE0 && rsp_corrected, "R4",
                "data bit repaired", 72'(rsp_data), 72'h1357_9BDF_2468_ACE0);
            cur_req = "R7";
            chk(scrub_req && scrub_addr == AW'(16'h400 + b), "R7", "scrub address",
                72'(scrub_addr), 72'(16'h400 + b));
            chk(scrub_word == ref_enc(64'h1357_9BDF_2468_ACE0), "R7", "scrub word",
                scrub_word, ref_enc(64'h1357_9BDF_2468_ACE0));
            cur_req = "R8";
            do_read(16'h4FF, ref_enc(64'd7));
            chk(!rsp_valid, "R8", "read while busy ignored", 72'(rsp_valid), 72'd0);
            @(negedge clk);
            cur_req = "R7";
            do_ack();
            chk(!scrub_req && rd_ready, "R7", "scrub released", 72'(scrub_req), 72'd0);
            cur_req = "R4";
        end

        cur_req = "R5";
        pat = 64'h0F0F_F0F0_1234_5678;
        for (int k = 64; k < 72; k += 3) begin
            do_read(16'h500, flip1(ref_enc(pat), k));
            chk(rsp_data == pat && rsp_corrected, "R5", "check bit fault", 72'(rsp_data), 72'(pat));
            do_ack();
        end
        do_read(16'h501, flip1(ref_enc(pat), 71));
        chk(rsp_data == pat && rsp_corrected, "R5", "overall parity bit fault", 72'(rsp_data), 72'(pat));
        do_ack();

        cur_req = "R6";
        cw = flip1(flip1(ref_enc(pat), 3), 50);
        do_read(16'h600, cw);
        chk(rsp_uncorrectable && !rsp_corrected && !scrub_req, "R6", "double fault",
            72'({rsp_uncorrectable, rsp_corrected, scrub_req}), 72'b100);
        chk(rsp_data == cw[63:0], "R6", "raw data on double fault", 72'(rsp_data), 72'(cw[63:0]));
        cw = flip1(flip1(ref_enc(pat), 64), 66);
        do_read(16'h601, cw);
        chk(rsp_uncorrectable, "R6", "double check-bit fault", 72'(rsp_uncorrectable), 72'd1);
        cw = flip1(flip1(flip1(ref_enc(64'd0), 64), 69), 70);
        do_read(16'h602, cw);
        chk(rsp_uncorrectable, "R6", "syndrome out of range", 72'(rsp_uncorrectable), 72'd1);

        cur_req = "R9";
        cfg_check_en = 1'b0;
        cw = flip1(ref_enc(pat), 9);
        do_read(16'h700, cw);
        chk(rsp_data == cw[63:0] && !rsp_corrected && !scrub_req, "R9", "bypass raw data",
            72'(rsp_data), 72'(cw[63:0]));
        cfg_check_en = 1'b1;

        cur_req = "R7";
        cfg_inj_data = 64'h10;
        cfg_inj_chk  = 8'h02;
        do_read(16'h710, flip1(ref_enc(pat), 20));
        chk(scrub_word == (ref_enc(pat) ^ {8'h02, 64'h10}), "R7", "scrub word with injection",
            scrub_word, ref_enc(pat) ^ {8'h02, 64'h10});
        repeat (3) @(negedge clk);
        do_ack();
        cfg_inj_data = '0;
        cfg_inj_chk  = '0;

        cur_req = "R10";
        for (int i = 0; i < 20; i++) begin
            do_read(AW'(i), flip1(ref_enc(64'(i) * 64'h1111), i % 72));
            do_ack();
        end
        chk(err_count == CW'(CMAX), "R10", "counter saturated", 72'(err_count), 72'(CMAX));

        cur_req = "R11";
        cfg_cnt_clr = 1'b1;
        @(negedge clk);
        cfg_cnt_clr = 1'b0;
        chk(err_count == '0, "R11", "counter cleared", 72'(err_count), 72'd0);
        do_read(16'h800, flip1(ref_enc(pat), 5));
        do_ack();
        cfg_cnt_clr = 1'b1;
        do_read(16'h801, flip1(ref_enc(pat), 6));
        cfg_cnt_clr = 1'b0;
        chk(err_count == '0, "R11", "clear beats increment", 72'(err_count), 72'd0);
        do_ack();

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule